// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that gives a host controller read and write access to a small bank of 8-bit configuration registers, such as per-output clock enable masks. The registers come out of reset holding a default value, so the system runs correctly even if the host never touches the bus. SCL and SDA arrive already synchronized to the system clock. The block drives SDA only by asserting an output enable that pulls the wire low.

The block recognises START and STOP and matches the fixed device address. It then takes a command byte. The top bit of the command selects the transfer type. When it is set, the transfer is a single-byte access and the low seven bits are the register offset. When it is clear, the transfer is a block access that always starts at register 0. A block write sends a count byte and then that many data bytes. A block read returns the count first and then the registers in ascending order. Every byte moves most significant bit first.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every register holds the reset-value parameter and the SDA output enable is low.
- R2: The first byte after a START is the 7-bit device address followed by the R/W bit (1 = read). The default address is 1101001, so the write form is D2h. A matching address is ACKed by pulling SDA low during the ninth clock. A mismatched address is not ACKed, and SDA stays released for every following byte until the next START.
- R3: A command byte with bit 7 = 1 is a single-byte access to the register whose index is in bits 6:0. In a byte write, the next byte is stored into that register.
- R4: A byte read is a command byte, then a repeated START, then the read address. The slave then returns the addressed register MSB first.
- R5: A command byte with bit 7 = 0 starts a block access at register 0. In a block write, a count byte follows and then the count data bytes, which are stored into registers 0, 1, 2 and so on. The slave ACKs every byte.
- R6: A block read is a block command, then a repeated START, then the read address. The slave sends first a count byte equal to the number of registers, then register 0 upward, while the master keeps ACKing. After the master NACKs, SDA stays released.
- R7: A write aimed at an index at or above the number of registers is ACKed and discarded. A read of such an index returns 00h.
- R8: A STOP after any complete byte ends a block write. The bytes already completed are kept and no other register changes.
- R9: A START or STOP in the middle of a byte aborts the transfer. The partial byte is never stored, the bit counter restarts, and the next transfer decodes normally.
- R10: The SDA output enable changes only while SCL is low. It is low in the cycle after any START or STOP.
- R11: Register contents change only on the eighth bit of a data byte that a write transfer is allowed to store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data, as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| cfg_o | output | NUM_REGS*8 | Register bank image, register i in bits [8i+7:8i] |

## Verification
The bench builds the block with six registers and a reset value of C3h. The non-default reset value makes the reset state distinguishable from an all-ones or all-zero bank. With only six registers, the block-read count byte is not a power of two, and offset 20h is out of range, which exercises the discard path of R7 and the 00h read of unimplemented registers. A behavioural register image in the bench is compared with the register outputs on every clock. That comparison catches a write that lands one byte early, on the wrong index, or from an aborted byte.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_CMD,
        S_COUNT,
        S_WDATA,
        S_RDATA,
        S_WAIT
    } smb_state_e;

    typedef struct packed {
        smb_state_e st;
        logic [3:0] bcnt;    // SCL rising edges seen in the current 9-bit frame
        logic [7:0] sh;      // receive shift register
        logic [7:0] tx;      // byte being transmitted
        logic       oe;      // SDA pull-down
        logic       ack;     // ACK to drive in the coming ninth slot
        logic [6:0] ptr;     // register index
        logic [7:0] remain;  // data bytes still allowed to store
        logic       blk;     // block access selected
        logic       cmd_ok;  // a command byte has been taken since START
        logic       first;   // read addressed, first byte not loaded yet
        logic       cnt_ph;  // next transmitted byte is the block count
        logic       load;    // load tx from the bank this cycle
    } smb_ctx_t;

endpackage

// File: rtl/smb_line_events.sv
module smb_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int         NUM_REGS = 8,
    parameter logic [7:0] RST_VAL  = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [6:0]            waddr,
    input  logic [7:0]            wdata,
    input  logic [6:0]            raddr,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= RST_VAL;
            else if (we && waddr == 7'(i))
                regs[i] <= wdata;
        end
        assign regs_o[i*8 +: 8] = regs[i];
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr == 7'(i))
                rdata = regs[i];
        end
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter logic [7:0] RST_VAL  = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam logic [6:0] REG_LIMIT  = 7'(NUM_REGS);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    smb_ctx_t   q, d;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       we;
    logic [7:0] nb, rdata;
    logic [6:0] wr_idx;
    logic [3:0] bit_pos;

    smb_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (q.ptr),
        .wdata  (nb),
        .raddr  (q.ptr),
        .rdata  (rdata),
        .regs_o (cfg_o)
    );

    always_comb begin
        d      = q;
        we     = 1'b0;
        nb     = {q.sh[6:0], sda_i};
        d.load = 1'b0;
        if (q.load)
            d.tx = q.cnt_ph ? COUNT_BYTE : rdata;

        if (start_det) begin
            d.st   = S_ADDR;
            d.bcnt = 4'd0;
            d.oe   = 1'b0;
            d.ack  = 1'b0;
        end else if (stop_det) begin
            d.st     = S_IDLE;
            d.bcnt   = 4'd0;
            d.oe     = 1'b0;
            d.ack    = 1'b0;
            d.cmd_ok = 1'b0;
        end else if (q.st == S_IDLE) begin
            d.oe = 1'b0;
        end else if (scl_rise) begin
            if (q.bcnt != 4'd8) begin
                d.sh   = nb;
                d.bcnt = q.bcnt + 4'd1;
                if (q.bcnt == 4'd7) begin
                    d.ack = 1'b0;
                    case (q.st)
                        S_ADDR: begin
                            if (nb[7:1] == DEV_ADDR) begin
                                d.ack = 1'b1;
                                if (nb[0]) begin
                                    d.st     = S_RDATA;
                                    d.first  = 1'b1;
                                    d.cnt_ph = q.cmd_ok & q.blk;
                                end else begin
                                    d.st = S_CMD;
                                end
                            end else begin
                                d.st = S_WAIT;
                            end
                        end
                        S_CMD: begin
                            d.ack    = 1'b1;
                            d.cmd_ok = 1'b1;
                            d.blk    = ~nb[7];
                            d.ptr    = nb[7] ? nb[6:0] : 7'd0;
                            d.remain = nb[7] ? 8'd1 : 8'd0;
                            d.st     = nb[7] ? S_WDATA : S_COUNT;
                        end
                        S_COUNT: begin
                            d.ack    = 1'b1;
                            d.remain = nb;
                            d.st     = S_WDATA;
                        end
                        S_WDATA: begin
                            d.ack = 1'b1;
                            if (q.remain != 8'd0) begin
                                we       = (q.ptr < REG_LIMIT);
                                d.ptr    = q.ptr + 7'd1;
                                d.remain = q.remain - 8'd1;
                            end
                        end
                        default: ;
                    endcase
                end
            end else begin
                d.bcnt = 4'd0;
                if (q.st == S_RDATA) begin
                    if (q.first) begin
                        d.first = 1'b0;
                        d.load  = 1'b1;
                    end else if (sda_i) begin
                        d.st = S_WAIT;
                    end else begin
                        if (q.cnt_ph) d.cnt_ph = 1'b0;
                        else          d.ptr    = q.ptr + 7'd1;
                        d.load = 1'b1;
                    end
                end
            end
        end else if (scl_fall) begin
            if (q.bcnt == 4'd8)
                d.oe = q.ack;
            else if (q.st == S_RDATA && !q.first)
                d.oe = ~q.tx[~q.bcnt[2:0]];
            else
                d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign wr_idx   = q.ptr;
    assign bit_pos  = q.bcnt;
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  we,
    input logic [6:0]            wr_idx,
    input logic [3:0]            bit_pos
);
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe_o); // R10

    AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_oe_o); // R9

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i); // R10

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_o)); // R11

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (wr_idx < 7'(NUM_REGS))); // R7

    AST_BIT_POS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos <= 4'd8); // R9
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o),
    .we       (we),
    .wr_idx   (wr_idx),
    .bit_pos  (bit_pos)
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
    localparam int         NR  = 6;
    localparam logic [7:0] RV  = 8'hC3;
    localparam int         QW  = 4;
    localparam logic [7:0] WRA = 8'hD2;
    localparam logic [7:0] RDA = 8'hD3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NR*8-1:0] cfg;
    wire  sda_bus = m_sda & ~sda_oe;

    logic [7:0] model [NR];
    int   checks = 0;
    int   fails = 0;
    int   oe_bad = 0;
    logic run = 1'b0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;

    smb_cfg_slave #(.NUM_REGS(NR), .RST_VAL(RV)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .cfg_o(cfg)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NR*8-1:0] image();
        logic [NR*8-1:0] v;
        for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    // R11: register image compared with the reference model on every clock
    always @(posedge clk) begin
        #1;
        if (run) begin
            chk(cfg == image(), "R11 register image", 64'(cfg), 64'(image()));
            if (sda_oe != prev_oe && scl) oe_bad++;
            prev_oe = sda_oe;
        end
    end

    task automatic wq();
        repeat (QW) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, input int cidx, input logic [7:0] cval, output logic r);
        m_sda = b;
        wq();
        scl = 1'b1;
        if (cidx >= 0 && cidx < NR) model[cidx] = cval;
        wq();
        r = sda_bus;
        wq();
        scl = 1'b0;
        wq();
    endtask

    task automatic send_byte(input logic [7:0] v, input int cidx, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_x(v[i], (i == 0) ? cidx : -1, v, r);
        bit_x(1'b1, -1, 8'h00, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_x(1'b1, -1, 8'h00, r);
            v[i] = r;
        end
        bit_x(~mack, -1, 8'h00, r);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wq();
        scl = 1'b1;   wq();
        m_sda = 1'b0; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; wq();
        scl = 1'b1;   wq();
        m_sda = 1'b1; wq();
        wq();
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] v, input string tag);
        logic a;
        do_start();
        send_byte(WRA, -1, a);           chk(a, {tag, " addr ack"}, 64'(a), 1);
        send_byte({1'b1, off}, -1, a);   chk(a, {tag, " cmd ack"}, 64'(a), 1);
        send_byte(v, int'(off), a);      chk(a, {tag, " data ack"}, 64'(a), 1);
        do_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, input logic [7:0] exp, input string tag);
        logic a;
        logic [7:0] v;
        do_start();
        send_byte(WRA, -1, a);
        send_byte({1'b1, off}, -1, a);
        do_start();
        send_byte(RDA, -1, a);           chk(a, {tag, " read addr ack"}, 64'(a), 1);
        recv_byte(1'b0, v);              chk(v == exp, {tag, " read data"}, 64'(v), 64'(exp));
        do_stop();
    endtask

    initial begin
        logic a, r;
        logic [7:0] v;
        for (int i = 0; i < NR; i++) model[i] = RV;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;
        chk(cfg == {NR{RV}}, "R1 reset values", 64'(cfg), 64'({NR{RV}}));
        chk(sda_oe == 1'b0, "R1 sda released", 64'(sda_oe), 0);

        // R2 + R3: byte write to register 3
        byte_write(7'd3, 8'h5A, "R3");
        // R4: byte read returns it
        byte_read(7'd3, 8'h5A, "R4");

        // R5: block write of four bytes into registers 0..3
        do_start();
        send_byte(WRA, -1, a);   chk(a, "R2 addr ack", 64'(a), 1);
        send_byte(8'h00, -1, a); chk(a, "R5 cmd ack", 64'(a), 1);
        send_byte(8'd4, -1, a);  chk(a, "R5 count ack", 64'(a), 1);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'h11 * 8'(i + 1), i, a);
            chk(a, "R5 data ack", 64'(a), 1);
        end
        do_stop();

        // R6: block read, count first then registers upward
        do_start();
        send_byte(WRA, -1, a);
        send_byte(8'h00, -1, a);
        do_start();
        send_byte(RDA, -1, a);   chk(a, "R6 read addr ack", 64'(a), 1);
        recv_byte(1'b1, v);      chk(v == 8'(NR), "R6 count byte", 64'(v), 64'(NR));
        for (int i = 0; i < NR; i++) begin
            recv_byte(i != NR - 1, v);
            chk(v == model[i], "R6 block data", 64'(v), 64'(model[i]));
        end
        bit_x(1'b1, -1, 8'h00, r);
        chk(r == 1'b1, "R6 released after NACK", 64'(r), 1);
        do_stop();

        // R2: wrong address is not ACKed, nor later bytes
        do_start();
        send_byte(8'hA4, -1, a); chk(!a, "R2 mismatch no ack", 64'(a), 0);
        send_byte(8'h81, -1, a); chk(!a, "R2 stays released", 64'(a), 0);
        do_stop();

        // R7: out-of-range write ACKed and discarded, read gives 00h
        byte_write(7'h20, 8'h77, "R7");
        byte_read(7'h20, 8'h00, "R7");

        // R8 + R9: block write stopped after two bytes, third byte cut by STOP
        do_start();
        send_byte(WRA, -1, a);
        send_byte(8'h00, -1, a);
        send_byte(8'd5, -1, a);
        send_byte(8'hAA, 0, a);  chk(a, "R8 data ack", 64'(a), 1);
        send_byte(8'hBB, 1, a);  chk(a, "R8 data ack", 64'(a), 1);
        for (int i = 0; i < 4; i++) bit_x(1'b1, -1, 8'h00, r);
        do_stop();
        byte_read(7'd2, model[2], "R8");

        // R9: START in the middle of a byte, then a clean byte write
        do_start();
        send_byte(WRA, -1, a);
        send_byte(8'h00, -1, a);
        send_byte(8'd3, -1, a);
        send_byte(8'h01, 0, a);
        for (int i = 0; i < 3; i++) bit_x(1'b0, -1, 8'h00, r);
        byte_write(7'd5, 8'h3C, "R9");
        byte_read(7'd5, 8'h3C, "R9");
        byte_read(7'd1, 8'hBB, "R9");

        chk(oe_bad == 0, "R10 oe changed while SCL high", 64'(oe_bad), 0);
        run = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule